// File: doc/BRIEF.md
# Reconfigurable Region Isolation Sequencer

This block guards one swappable region of a partially reconfigurable design during a module exchange. It sits between the static producer/consumer interface and the module loaded in the region. It also takes part in a request/acknowledge handshake with the reconfiguration controller. The controller asks for a swap by pulling an active-low request low. The sequencer grants the swap only once the loaded module reports that it is idle.

From the grant onward the static side sees fixed safe values instead of the module outputs. Both ready lines read 0 and the consumer error line reads 1, so any transfer that is still pending gets cancelled rather than left hanging. When the controller signals that the new module is in place, the sequencer holds the module reset for a parameterised number of cycles. Isolation is lifted one cycle after that reset ends.

A swap that starts without a granted handshake raises a sticky protocol error flag, and isolation is applied anyway.

Top module: `rr_swap_sequencer`

## Requirements
- R1: `ackN` stays high while `modIdle` is low. It falls at the first clock edge that samples `reqN` low and `modIdle` high in the waiting state.
- R2: Once low, `ackN` stays low until an edge samples `reqN` high, and it rises at that edge.
- R3: While isolated, `staticProdReady` is 0 whatever the module drives.
- R4: While isolated, `staticConsReady` is 0 and `staticConsError` is 1 whatever the module drives.
- R5: While not isolated, the three static outputs equal the module outputs in the same cycle.
- R6: `modRst` is low until the swap completes. It goes high at the edge that samples `swapDone` high in the isolating state and stays high for exactly RST_CYCLES cycles (default 4).
- R7: Isolation continues for exactly one cycle after `modRst` falls, then ends.
- R8: If the request is withdrawn before the module is idle, the sequencer returns to idle without acknowledging and without isolating.
- R9: If `swapBusy` is sampled high while no grant is being given, `protoErr` goes high at that edge and stays high until reset. Isolation starts at the same edge.
- R10: After reset, `ackN` is 1, `modRst` is 0, `protoErr` is 0 and the static outputs follow the module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | 1 | Swap request from controller, active low |
| modIdle | input | 1 | Loaded module reports idle |
| swapBusy | input | 1 | Swap in progress |
| swapDone | input | 1 | New module in place |
| modProdReady | input | 1 | Module producer-ready output |
| modConsReady | input | 1 | Module consumer-ready output |
| modConsError | input | 1 | Module consumer-error output |
| ackN | output | 1 | Swap acknowledge, active low |
| staticProdReady | output | 1 | Producer-ready seen by static side |
| staticConsReady | output | 1 | Consumer-ready seen by static side |
| staticConsError | output | 1 | Consumer-error seen by static side |
| modRst | output | 1 | Reset to the reconfigurable module |
| protoErr | output | 1 | Sticky flag for a swap without a grant |

## Verification
The checks assume that the controller behaves: `swapDone` comes only after a granted swap, and the request is released only after `swapDone`. Only the dedicated error case breaks that rule. The random stimulus therefore runs whole handshakes with random delays for idle, swap length and release. The module outputs toggle freely every cycle. Directed runs then cover a withdrawn request and an unsolicited swap, and the error run comes last because its flag is sticky.

// File: rtl/rr_swap_pkg.sv
package rr_swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_IDLE,
    ST_ISOLATE,
    ST_RESET,
    ST_RELEASE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setGrant;
    logic clrGrant;
    logic setErr;
    logic loadCnt;
    logic decCnt;
    logic isolate;
    logic holdRst;
  } seqStrobe_t;
endpackage

// File: rtl/rr_swap_ctrl.sv
module rr_swap_ctrl
  import rr_swap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqN,
  input  logic       modIdle,
  input  logic       swapBusy,
  input  logic       swapDone,
  input  logic       grantHeld,
  input  logic       cntZero,
  output seqStrobe_t strobe
);
  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD          = stateQ;
    strobe          = '0;
    strobe.clrGrant = reqN;
    unique case (stateQ)
      ST_IDLE: begin
        if (swapBusy) begin
          strobe.setErr = 1'b1;
          stateD        = ST_ISOLATE;
        end else if (!reqN && !grantHeld) begin
          stateD = ST_WAIT_IDLE;
        end
      end
      ST_WAIT_IDLE: begin
        if (!reqN && modIdle) begin
          strobe.setGrant = 1'b1;
          stateD          = ST_ISOLATE;
        end else if (swapBusy) begin
          strobe.setErr = 1'b1;
          stateD        = ST_ISOLATE;
        end else if (reqN) begin
          stateD = ST_IDLE;
        end
      end
      ST_ISOLATE: begin
        strobe.isolate = 1'b1;
        if (swapDone) begin
          strobe.loadCnt = 1'b1;
          stateD         = ST_RESET;
        end
      end
      ST_RESET: begin
        strobe.isolate = 1'b1;
        strobe.holdRst = 1'b1;
        if (cntZero) stateD = ST_RELEASE;
        else         strobe.decCnt = 1'b1;
      end
      ST_RELEASE: begin
        strobe.isolate = 1'b1;
        stateD         = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rr_swap_datapath.sv
module rr_swap_datapath
  import rr_swap_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       modProdReady,
  input  logic       modConsReady,
  input  logic       modConsError,
  output logic       grantHeld,
  output logic       cntZero,
  output logic       ackN,
  output logic       staticProdReady,
  output logic       staticConsReady,
  output logic       staticConsError,
  output logic       modRst,
  output logic       protoErr
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cntQ;
  logic             grantQ;
  logic             errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.loadCnt) begin
      cntQ <= CNT_LOAD;
    end else if (strobe.decCnt) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (strobe.setGrant)      grantQ <= 1'b1;
      else if (strobe.clrGrant) grantQ <= 1'b0;
      if (strobe.setErr)        errQ   <= 1'b1;
    end
  end

  assign grantHeld = grantQ;
  assign cntZero   = (cntQ == '0);
  assign ackN      = ~grantQ;
  assign modRst    = strobe.holdRst;
  assign protoErr  = errQ;

  // safe defaults toward the static region while isolated
  always_comb begin
    if (strobe.isolate) begin
      staticProdReady = 1'b0;
      staticConsReady = 1'b0;
      staticConsError = 1'b1;
    end else begin
      staticProdReady = modProdReady;
      staticConsReady = modConsReady;
      staticConsError = modConsError;
    end
  end
endmodule

// File: rtl/rr_swap_sequencer.sv
module rr_swap_sequencer
  import rr_swap_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqN,
  input  logic modIdle,
  input  logic swapBusy,
  input  logic swapDone,
  input  logic modProdReady,
  input  logic modConsReady,
  input  logic modConsError,
  output logic ackN,
  output logic staticProdReady,
  output logic staticConsReady,
  output logic staticConsError,
  output logic modRst,
  output logic protoErr
);
  seqStrobe_t strobe;
  logic       grantHeld;
  logic       cntZero;

  rr_swap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqN      (reqN),
    .modIdle   (modIdle),
    .swapBusy  (swapBusy),
    .swapDone  (swapDone),
    .grantHeld (grantHeld),
    .cntZero   (cntZero),
    .strobe    (strobe)
  );

  rr_swap_datapath #(.RST_CYCLES(RST_CYCLES)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .modProdReady    (modProdReady),
    .modConsReady    (modConsReady),
    .modConsError    (modConsError),
    .grantHeld       (grantHeld),
    .cntZero         (cntZero),
    .ackN            (ackN),
    .staticProdReady (staticProdReady),
    .staticConsReady (staticConsReady),
    .staticConsError (staticConsError),
    .modRst          (modRst),
    .protoErr        (protoErr)
  );
endmodule

// File: rtl/rr_swap_checker.sv
module rr_swap_checker (
  input logic clk,
  input logic rstN,
  input logic reqN,
  input logic modIdle,
  input logic swapDone,
  input logic ackN,
  input logic staticProdReady,
  input logic staticConsReady,
  input logic staticConsError,
  input logic modRst,
  input logic protoErr
);
  // R1
  ack_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> ($past(modIdle) && !$past(reqN)));

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && !reqN) |=> !ackN);

  // R3
  prod_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    modRst |-> !staticProdReady);

  // R4
  cons_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    modRst |-> (!staticConsReady && staticConsError));

  // R6
  reset_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modRst) |-> $past(swapDone));

  // R7
  release_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modRst) |-> (staticConsError && !staticProdReady));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind rr_swap_sequencer rr_swap_checker u_chk (.*);

// File: tb/tb_rr_swap_sequencer.sv
module tb_rr_swap_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYCLES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqN = 1'b1, modIdle = 1'b0, swapBusy = 1'b0, swapDone = 1'b0;
  logic modProdReady = 1'b0, modConsReady = 1'b0, modConsError = 1'b0;
  logic ackN, staticProdReady, staticConsReady, staticConsError, modRst, protoErr;

  int vectors = 0;
  int misses  = 0;

  // model: 0 idle, 1 wait, 2 isolate, 3 reset, 4 release
  int mSt = 0;
  int mCnt = 0;
  bit mGrant = 0;
  bit mErr = 0;

  rr_swap_sequencer #(.RST_CYCLES(RST_CYCLES)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isoExp();
    return (mSt >= 2);
  endfunction

  task automatic modelUpdate();
    int nSt = mSt;
    bit g = mGrant;
    case (mSt)
      0: if (swapBusy) begin mErr = 1; nSt = 2; end
         else if (!reqN && !mGrant) nSt = 1;
      1: if (!reqN && modIdle) begin g = 1; nSt = 2; end
         else if (swapBusy) begin mErr = 1; nSt = 2; end
         else if (reqN) nSt = 0;
      2: if (swapDone) begin nSt = 3; mCnt = RST_CYCLES; end
      3: begin mCnt--; if (mCnt == 0) nSt = 4; end
      default: nSt = 0;
    endcase
    if (reqN && !(mSt == 1 && !reqN && modIdle)) g = 0;
    mGrant = g;
    mSt = nSt;
  endtask

  task automatic tick(bit r, bit i, bit b, bit d);
    @(negedge clk);
    reqN = r; modIdle = i; swapBusy = b; swapDone = d;
    modProdReady = 1'($urandom); modConsReady = 1'($urandom); modConsError = 1'($urandom);
    #1;
    chk(mSt == 1 ? "R1 ackN" : "R2 ackN", ackN, !mGrant);
    chk(isoExp() ? (mSt == 4 ? "R7 prod" : "R3 prod") : "R5 prod",
        staticProdReady, isoExp() ? 1'b0 : modProdReady);
    chk(isoExp() ? "R4 consReady" : "R5 consReady", staticConsReady, isoExp() ? 1'b0 : modConsReady);
    chk(isoExp() ? "R4 consError" : "R5 consError", staticConsError, isoExp() ? 1'b1 : modConsError);
    chk("R6 modRst", modRst, mSt == 3);
    chk("R9 protoErr", protoErr, mErr);
    @(posedge clk);
    modelUpdate();
  endtask

  task automatic swapRun(int idleDly, int busyLen, int relDly);
    for (int k = 0; k < idleDly; k++) tick(0, 0, 0, 0);
    tick(0, 1, 0, 0);
    tick(0, 1, 0, 0);
    for (int k = 0; k < busyLen; k++) tick(0, 0, 1, 0);
    tick(0, 0, 0, 1);
    for (int k = 0; k < relDly; k++) tick(0, 0, 0, 0);
    for (int k = 0; k < RST_CYCLES + 4; k++) tick(1, 1, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    #1;
    chk("R10 ackN", ackN, 1'b1);
    chk("R10 modRst", modRst, 1'b0);
    chk("R10 protoErr", protoErr, 1'b0);
    chk("R10 consError", staticConsError, modConsError);
    tick(1, 0, 0, 0);

    // minimum delays and a long wait for idle
    swapRun(0, 1, 0);
    swapRun(7, 5, 3);

    for (int n = 0; n < 300; n++)
      swapRun(int'($urandom_range(0, 6)), int'($urandom_range(0, 8)), int'($urandom_range(0, 5)));

    // R8 withdrawn request: no ack, no isolation
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    tick(1, 1, 0, 0);
    chk("R8 ackN", ackN, 1'b1);
    chk("R8 isolation", staticConsError, modConsError);

    // R9 unsolicited swap: error and isolation at the same edge
    tick(1, 0, 1, 0);
    tick(1, 0, 1, 0);
    chk("R9 isolation", staticConsError, 1'b1);
    chk("R9 protoErr", protoErr, 1'b1);
    tick(1, 0, 0, 1);
    for (int k = 0; k < RST_CYCLES + 4; k++) tick(1, 0, 0, 0);
    chk("R9 sticky", protoErr, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule